// File: doc/BRIEF.md
# Mask-Directed Bit Mover with Masked Increment

This unit works on 64-bit words. For each operation it takes a data word, a source mask and a destination mask. The move operation gathers the data bits picked out by the source mask, lowest first, and lays them down, lowest first, in the positions that the destination mask marks. The same datapath therefore packs scattered bits into a dense field when the destination mask is a low contiguous run. It unpacks a dense field into scattered positions when the source mask is a low contiguous run. Any mix of the two rearranges bits in a single step.

The second operation treats the bits under the source mask as one counter whose digits are spread across the word, and adds one to it. The carry enters at the lowest masked position and moves only through masked positions. Repeated steps starting from zero therefore walk through every subset of the mask and come back to zero. A wrap flag marks that return.

Operands arrive on a valid/ready handshake that never stalls. The result and its flags are registered and appear one clock after the operation is accepted.

Top module: `mbm_top`

## Requirements
- R1: For move (opCode 2'b00), the data bit at the k-th lowest set position of srcMask appears at the k-th lowest set position of dstMask in resData.
- R2: For move, a resData bit is zero where dstMask is clear, where the dstMask position has no matching source bit, or where the carried data bit is zero.
- R3: For move with a dstMask that is a low contiguous run of ones, the selected data bits end up packed at bit 0 upward in source order.
- R4: For move with a srcMask that is a low contiguous run of ones, the low data bits are spread out in order onto the set positions of dstMask.
- R5: For move, when srcMask has more set bits than dstMask, the extra higher-ranked selected bits are discarded.
- R6: For masked increment (opCode 2'b01), resData equals (dataIn AND srcMask) plus one, with the carry propagating only through the set positions of srcMask. Bits outside srcMask are zero in the result. Data bits outside srcMask and the value of dstMask have no effect.
- R7: Masked increment applied repeatedly, starting from zero and feeding each result back as data, produces a distinct subset of srcMask at every step and returns to zero after 2^popcount(srcMask) steps.
- R8: resWrap is 1 exactly when a masked increment yields zero. It is 0 for every other opcode.
- R9: opCode 2'b10 and 2'b11 produce resData zero and resWrap zero.
- R10: opReady is always 1. An operation accepted at a clock edge shows its result, with resValid high, right after the next edge. Operations may be issued on consecutive cycles.
- R11: While rstN is low, resValid, resData and resWrap are all zero.
- R12: In a cycle with no accepted operation, resValid goes low and resData and resWrap keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operand set is present |
| opReady | output | 1 | Unit can accept an operand set (always high) |
| opCode | input | 2 | 00 move, 01 masked increment, others reserved |
| dataIn | input | 64 | Data word |
| srcMask | input | 64 | Source selection mask (also the counter mask for increment) |
| dstMask | input | 64 | Destination placement mask |
| resValid | output | 1 | Result register holds a fresh result |
| resData | output | 64 | Registered result |
| resWrap | output | 1 | Masked increment returned to zero |

## Verification
The assertions check properties that hold on every cycle. A moved result never sets a bit outside the destination mask and never holds more ones than the source selection offered. An increment result stays inside its mask. A wrap always comes with a zero result. Reserved opcodes clear the result. resValid follows acceptance by one cycle, and the result holds when nothing is accepted. Only the bench scenarios can show that bits land in the right rank order, that excess source bits are dropped, that the carry skips unmasked positions, and that a full enumeration visits each subset once before it wraps.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_INC   = 2'd1,
    OP_RSV_A = 2'd2,
    OP_RSV_B = 2'd3
  } mbmOp_e;

  typedef struct packed {
    logic   load;
    mbmOp_e kind;
  } mbmStrobe_t;

endpackage

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  output logic       opReady,
  output mbmStrobe_t strobe,
  output logic       resValid
);

  // The datapath is single-cycle, so the unit never applies backpressure.
  assign opReady     = 1'b1;
  assign strobe.load = opValid & opReady;
  assign strobe.kind = mbmOp_e'(opCode);

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= strobe.load;
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid); // R10
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid); // R12

endmodule

// File: rtl/mbm_compress.sv
module mbm_compress #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] selMask,
  output logic [WIDTH-1:0] packedOut
);

  localparam int IDX_W = $clog2(WIDTH);
  localparam logic [IDX_W:0] ONE = 1;

  // Selected bits are written, in ascending order, to the next free slot from bit 0 upward.
  always_comb begin
    logic [IDX_W:0] slot;
    packedOut = '0;
    slot      = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (selMask[i]) begin
        packedOut[slot[IDX_W-1:0]] = dataIn[i];
        slot = slot + ONE;
      end
    end
  end

endmodule

// File: rtl/mbm_expand.sv
module mbm_expand #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] packedIn,
  input  logic [WIDTH-1:0] placeMask,
  output logic [WIDTH-1:0] spreadOut
);

  localparam int IDX_W = $clog2(WIDTH);

  // rankAt[j] counts the placeMask ones below position j.
  logic [IDX_W:0] rankAt [WIDTH];

  assign rankAt[0] = '0;

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    if (j < WIDTH - 1) begin : g_rank
      assign rankAt[j+1] = rankAt[j] + {{IDX_W{1'b0}}, placeMask[j]};
    end
    assign spreadOut[j] = placeMask[j] & packedIn[rankAt[j][IDX_W-1:0]];
  end

endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath
  import mbm_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbmStrobe_t       strobe,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] srcMask,
  input  logic [WIDTH-1:0] dstMask,
  output logic [WIDTH-1:0] resData,
  output logic             resWrap
);

  logic [WIDTH-1:0] packedBits;
  logic [WIDTH-1:0] moveRes;
  logic [WIDTH-1:0] maskedData;
  logic [WIDTH-1:0] incRes;
  logic [WIDTH-1:0] nextData;
  logic             nextWrap;

  mbm_compress #(.WIDTH(WIDTH)) i_compress (
    .dataIn   (dataIn),
    .selMask  (srcMask),
    .packedOut(packedBits)
  );

  mbm_expand #(.WIDTH(WIDTH)) i_expand (
    .packedIn (packedBits),
    .placeMask(dstMask),
    .spreadOut(moveRes)
  );

  // Subtracting the mask borrows through the clear (unmasked) positions,
  // so the carry only advances through masked bits.
  assign maskedData = dataIn & srcMask;
  assign incRes     = (maskedData - srcMask) & srcMask;

  always_comb begin
    nextData = '0;
    nextWrap = 1'b0;
    case (strobe.kind)
      OP_MOVE: nextData = moveRes;
      OP_INC: begin
        nextData = incRes;
        nextWrap = (incRes == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resWrap <= 1'b0;
    end else if (strobe.load) begin
      resData <= nextData;
      resWrap <= nextWrap;
    end
  end

  AST_MOVE_IN_DST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == OP_MOVE) |=> ((resData & ~$past(dstMask)) == '0)); // R2
  AST_MOVE_NO_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == OP_MOVE)
      |=> ($countones(resData) <= $countones($past(dataIn & srcMask)))); // R5
  AST_INC_IN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == OP_INC) |=> ((resData & ~$past(srcMask)) == '0)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    resWrap |-> (resData == '0)); // R8
  AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind[1]) |=> (resData == '0 && !resWrap)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resData) && $stable(resWrap))); // R12

endmodule

// File: rtl/mbm_top.sv
module mbm_top
  import mbm_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  output logic             opReady,
  input  logic [1:0]       opCode,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] srcMask,
  input  logic [WIDTH-1:0] dstMask,
  output logic             resValid,
  output logic [WIDTH-1:0] resData,
  output logic             resWrap
);

  mbmStrobe_t strobe;

  mbm_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .opReady (opReady),
    .strobe  (strobe),
    .resValid(resValid)
  );

  mbm_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dataIn (dataIn),
    .srcMask(srcMask),
    .dstMask(dstMask),
    .resData(resData),
    .resWrap(resWrap)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!resValid && resData == '0 && !resWrap)); // R11

endmodule

// File: tb/test_mbm_top.sv
`timescale 1ns/1ps
module test_mbm_top;

  localparam int W = 64;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic         opReady;
  logic [1:0]   opCode = 2'd0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] srcMask = '0;
  logic [W-1:0] dstMask = '0;
  logic         resValid;
  logic [W-1:0] resData;
  logic         resWrap;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mbm_top i_mbm_top (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opCode(opCode), .dataIn(dataIn), .srcMask(srcMask), .dstMask(dstMask),
    .resValid(resValid), .resData(resData), .resWrap(resWrap)
  );

  // Vector table: opcode, data, source mask, destination mask, expected result, expected wrap.
  localparam int N = 15;
  localparam logic [1:0] T_OP [N] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 2, 3, 1, 1, 0};
  localparam logic [W-1:0] T_D [N] = '{
    ONES, 64'hA0, 64'h5, ONES, 64'h1, ONES, 64'h0, 64'h1, 64'h0101, 64'hFFFE,
    ONES, ONES, 64'h5, ONES, 64'hF000_0000_0000_0000};
  localparam logic [W-1:0] T_S [N] = '{
    64'hF0, 64'hF0, 64'hF, 64'hFF, 64'h1, 64'h1, 64'h0101, 64'h0101, 64'h0101, 64'h0101,
    ONES, ONES, ONES, ONES, 64'hFF00_0000_0000_0000};
  localparam logic [W-1:0] T_M [N] = '{
    64'h0F, 64'h0F, 64'h8000_0000_0000_0111, 64'h3, 64'h8000_0000_0000_0000, 64'hF0,
    64'h0, 64'h0, 64'h0, ONES, ONES, ONES, 64'h0, 64'h0, 64'hFF};
  localparam logic [W-1:0] T_E [N] = '{
    64'h0F, 64'h0A, 64'h101, 64'h3, 64'h8000_0000_0000_0000, 64'h10,
    64'h1, 64'h100, 64'h0, 64'h0101, 64'h0, 64'h0, 64'h6, 64'h0, 64'hF0};
  localparam logic T_W [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0};
  localparam string T_R [N] = '{"R3", "R3", "R4", "R5", "R1", "R2", "R6", "R6", "R8",
                                "R6", "R9", "R9", "R6", "R8", "R3"};

  function automatic logic [W-1:0] refMove(logic [W-1:0] d, logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] o = '0;
    int rank = 0;
    for (int j = 0; j < W; j++) begin
      if (m[j]) begin
        int seen = 0;
        for (int i = 0; i < W; i++) begin
          if (s[i]) begin
            if (seen == rank) o[j] = d[i];
            seen++;
          end
        end
        rank++;
      end
    end
    return o;
  endfunction

  function automatic logic [W-1:0] refInc(logic [W-1:0] d, logic [W-1:0] m);
    logic [W-1:0] o = '0;
    logic carry = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        o[i]  = d[i] ^ carry;
        carry = d[i] & carry;
      end
    end
    return o;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp,
                       logic actW, logic expW, logic actV, logic expV);
    checks++;
    if (act !== exp || actW !== expW || actV !== expV) begin
      fails++;
      $display("FAIL %s: data=%h wrap=%b valid=%b expected data=%h wrap=%b valid=%b",
               req, act, actW, actV, exp, expW, expV);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [W-1:0] d, logic [W-1:0] s, logic [W-1:0] m);
    opValid = 1'b1; opCode = op; dataIn = d; srcMask = s; dstMask = m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10: watchdog expired, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    logic [W-1:0] seed;
    logic [W-1:0] cur;
    logic [W-1:0] seenOr;
    logic [W-1:0] expD;
    logic expW;
    // R11: reset state, with an operation offered while reset is asserted.
    drive(2'd0, ONES, ONES, ONES);
    repeat (3) @(negedge clk);
    check("R11", resData, '0, resWrap, 1'b0, resValid, 1'b0);
    checks++;
    if (opReady !== 1'b1) begin fails++; $display("FAIL R10: opReady=%b expected=1", opReady); end
    opValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // Table walked back to back: one issue per cycle (R10).
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) check(T_R[i-1], resData, T_E[i-1], resWrap, T_W[i-1], resValid, 1'b1);
      drive(T_OP[i], T_D[i], T_S[i], T_M[i]);
    end
    @(negedge clk);
    check(T_R[N-1], resData, T_E[N-1], resWrap, T_W[N-1], resValid, 1'b1);

    // R12: idle cycles with changing inputs leave the result untouched.
    opValid = 1'b0; prev = resData;
    dataIn = 64'h1234; srcMask = ONES; dstMask = ONES; opCode = 2'd0;
    @(negedge clk);
    check("R12", resData, prev, resWrap, T_W[N-1], resValid, 1'b0);
    opCode = 2'd1;
    @(negedge clk);
    check("R12", resData, prev, resWrap, T_W[N-1], resValid, 1'b0);

    // R7: full enumeration of a sparse 4-bit mask, feeding results back.
    cur = '0; seenOr = '0;
    for (int step = 1; step <= 16; step++) begin
      drive(2'd1, cur | 64'h0F00_0000_0000_0000, 64'h8000_0000_0001_0402, 64'h0);
      @(negedge clk);
      opValid = 1'b0;
      expD = refInc(cur, 64'h8000_0000_0001_0402);
      expW = (step == 16);
      check("R7", resData, expD, resWrap, expW, resValid, 1'b1);
      if (step < 16) begin
        checks++;
        if ((seenOr & (64'h1 << step)) != 0 || expD == '0) begin
          fails++; $display("FAIL R7: step %0d value=%h expected=new nonzero subset", step, resData);
        end
      end
      cur = resData;
      seenOr = seenOr | (64'h1 << step);
    end
    check("R7", cur, '0, resWrap, 1'b1, resValid, 1'b1);

    // R1/R6: pseudo-random patterns against the rank-based and ripple models.
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] d, s, m;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17); d = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17); s = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17); m = seed;
      if (k[0]) s = s & (s >> 3);
      drive({1'b0, k[1]}, d, s, m);
      @(negedge clk);
      opValid = 1'b0;
      if (k[1]) check("R6", resData, refInc(d, s), resWrap, refInc(d, s) == '0, resValid, 1'b1);
      else      check("R1", resData, refMove(d, s, m), resWrap, 1'b0, resValid, 1'b1);
    end

    // R11: reset mid-run clears a nonzero result.
    drive(2'd0, ONES, ONES, ONES);
    @(negedge clk);
    opValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R11", resData, '0, resWrap, 1'b0, resValid, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule